// File: doc/BRIEF.md
# Queue DMA Channel Register File

This block holds the software-visible control state for a multi-channel, queue-driven DMA engine. Software reaches it over a plain 32-bit register port with a write strobe and an address. A read returns data in the same cycle as the address. Every channel owns a 256-byte window, and the channel number is taken from the address bits above bit 7. Each window stores the following:

- the base addresses and depths of a submission ring and a completion ring;
- the producer tail pointer of the submission ring and the consumer head pointer of the completion ring;
- enable, pause and reset controls;
- a status word for the channel's state machine;
- thirteen interrupt cause bits and their mask.

A single global register selects root-complex operation.

Each channel keeps a small state machine that software polls. The channel is IDLE when it is disabled or has nothing queued. It is RUN when it is enabled, not paused, and the submission tail differs from an internal consumer pointer. It is PAUSED when it is enabled with pause set. The data mover outside this block pulses a per-channel done strobe for every finished entry. That pulse advances the consumer pointer around the ring and raises interrupt cause 0. Other engine events raise causes through a per-channel cause vector. Each channel drives one interrupt line, which is high while any unmasked cause is pending.

Top module: `dma_chan_regfile`

## Requirements
- R1: Address bits [AW-1:8] select the channel window, and bits [7:0] select the register inside it. A window whose channel number is NCH or more reads as zero and ignores writes.
- R2: The ring base registers are full 32-bit read/write registers: submission low at 0x00, submission high at 0x04, completion low at 0x10 and completion high at 0x14. The depth registers (0x08, 0x18), the submission tail (0x0C) and the completion head (0x1C) keep the low PTR_W bits and read back zero-extended. A depth value is the number of ring entries minus one.
- R3: The control register at 0x20 holds enable in bit 0 and pause in bit 4. Its other bits read as zero.
- R4: Writing 1 to bit 0 of 0x24 sets a reset request that reads back 1 for exactly one cycle and then 0. The reset request clears the submission tail, the completion head and the consumer pointer, and it puts the state into IDLE. It has priority over a register write in that cycle.
- R5: The state appears at 0x30 in bits 3:0, encoded as IDLE=0, RUN=1 and PAUSED=2. One cycle after the controls or the pointers change, the state becomes IDLE if the channel is disabled, PAUSED if it is enabled and paused, RUN if it is enabled with the tail different from the consumer pointer, and IDLE otherwise.
- R6: A done pulse on a channel that is in RUN advances its consumer pointer by one. The pointer wraps to 0 after the value in the submission depth register. The same pulse sets interrupt status bit 0. A done pulse on a channel in any other state has no effect.
- R7: The interrupt status at 0x40 holds bits 12:0. Cause inputs set these bits, and a write of 1 clears a bit. A cause that arrives in the same cycle as a clear of that bit wins, so the bit stays set.
- R8: The interrupt mask at 0x44 holds bits 12:0 and resets to all ones. A channel's interrupt line is high while any status bit is set whose mask bit is 0.
- R9: The global mode register at 0x217C is a 1-bit read/write register in bit 0 that resets to 0.
- R10: Inside an in-range window, every offset not listed above reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, available in the same cycle |
| done_i | input | NCH | One-cycle pulse for each finished submission entry, one bit per channel |
| cause_i | input | NCH*13 | Interrupt cause set pulses, 13 bits per channel |
| irq_o | output | NCH | Per-channel interrupt lines |

## Verification
A consumer pointer that drifts has a visible symptom. The state reads RUN after the ring should have drained, or it reads IDLE too early, and the error shows at the first status read after the last done pulse. A state machine that does not react to a control write shows up one cycle later as a wrong code at 0x30. A decode error that aliases windows corrupts some other channel's readback in the full register sweep. A reset request that does not clear itself leaves 0x24 reading 1 two cycles after the write.

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile #(
  parameter int NCH   = 30,
  parameter int AW    = 16,
  parameter int PTR_W = 16,
  parameter int NCAUSE = 13,
  parameter logic [15:0] MODE_ADDR = 16'h217C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic [NCH-1:0]        done_i,
  input  logic [NCH*NCAUSE-1:0] cause_i,
  output logic [NCH-1:0]        irq_o
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [1:0] S_IDLE = 2'd0, S_RUN = 2'd1, S_PAUSE = 2'd2;

  logic [NCH-1:0][31:0]       sqb_lo, sqb_hi, cqb_lo, cqb_hi;
  logic [NCH-1:0][PTR_W-1:0]  sq_dep, cq_dep, sq_tail, cq_head, cons;
  logic [NCH-1:0]             en_q, pause_q, rst_q;
  logic [NCH-1:0][1:0]        st_q;
  logic [NCH-1:0][NCAUSE-1:0] sts_q, msk_q;
  logic                       mode_q;

  logic [AW-9:0] ch;
  logic [7:0]    off;
  logic [CW-1:0] ci;
  logic          ch_ok, mode_hit;

  assign ch       = addr[AW-1:8];
  assign off      = addr[7:0];
  assign ci       = CW'(ch);
  assign ch_ok    = (int'(ch) < NCH);
  assign mode_hit = (addr == AW'(MODE_ADDR));

  for (genvar g = 0; g < NCH; g++) begin : g_irq
    assign irq_o[g] = |(sts_q[g] & ~msk_q[g]);
  end

  always_comb begin
    rdata = '0;
    if (mode_hit) rdata = {31'b0, mode_q};
    else if (ch_ok) begin
      case (off)
        8'h00: rdata = sqb_lo[ci];
        8'h04: rdata = sqb_hi[ci];
        8'h08: rdata = 32'(sq_dep[ci]);
        8'h0C: rdata = 32'(sq_tail[ci]);
        8'h10: rdata = cqb_lo[ci];
        8'h14: rdata = cqb_hi[ci];
        8'h18: rdata = 32'(cq_dep[ci]);
        8'h1C: rdata = 32'(cq_head[ci]);
        8'h20: rdata = {27'b0, pause_q[ci], 3'b0, en_q[ci]};
        8'h24: rdata = {31'b0, rst_q[ci]};
        8'h30: rdata = {30'b0, st_q[ci]};
        8'h40: rdata = 32'(sts_q[ci]);
        8'h44: rdata = 32'(msk_q[ci]);
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      sqb_lo  <= '0; sqb_hi <= '0; cqb_lo <= '0; cqb_hi <= '0;
      sq_dep  <= '0; cq_dep <= '0; sq_tail <= '0; cq_head <= '0; cons <= '0;
      en_q    <= '0; pause_q <= '0; rst_q <= '0;
      st_q    <= '0; sts_q <= '0; msk_q <= '1;
    end else begin
      if (wr_en && mode_hit) mode_q <= wdata[0];
      for (int c = 0; c < NCH; c++) begin
        logic hit, acc;
        logic [NCAUSE-1:0] clr;
        hit = wr_en && !mode_hit && ch_ok && (ci == CW'(c));
        acc = done_i[c] && (st_q[c] == S_RUN) && !rst_q[c];
        clr = (hit && off == 8'h40) ? wdata[NCAUSE-1:0] : '0;
        rst_q[c] <= 1'b0;
        if (hit) begin
          case (off)
            8'h00: sqb_lo[c]  <= wdata;
            8'h04: sqb_hi[c]  <= wdata;
            8'h08: sq_dep[c]  <= wdata[PTR_W-1:0];
            8'h0C: sq_tail[c] <= wdata[PTR_W-1:0];
            8'h10: cqb_lo[c]  <= wdata;
            8'h14: cqb_hi[c]  <= wdata;
            8'h18: cq_dep[c]  <= wdata[PTR_W-1:0];
            8'h1C: cq_head[c] <= wdata[PTR_W-1:0];
            8'h20: begin en_q[c] <= wdata[0]; pause_q[c] <= wdata[4]; end
            8'h24: rst_q[c]   <= wdata[0];
            8'h44: msk_q[c]   <= wdata[NCAUSE-1:0];
            default: ;
          endcase
        end
        sts_q[c] <= (sts_q[c] & ~clr) | cause_i[c*NCAUSE +: NCAUSE]
                    | {{(NCAUSE-1){1'b0}}, acc};
        if (acc) cons[c] <= (cons[c] == sq_dep[c]) ? '0 : cons[c] + 1'b1;
        if (!en_q[c])                   st_q[c] <= S_IDLE;
        else if (pause_q[c])            st_q[c] <= S_PAUSE;
        else if (sq_tail[c] != cons[c]) st_q[c] <= S_RUN;
        else                            st_q[c] <= S_IDLE;
        if (rst_q[c]) begin
          sq_tail[c] <= '0;
          cq_head[c] <= '0;
          cons[c]    <= '0;
          st_q[c]    <= S_IDLE;
        end
      end
    end
  end
endmodule

module dma_chan_regfile_chk #(
  parameter int NCH = 30,
  parameter int NCAUSE = 13
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCH-1:0]        rst_q,
  input logic [NCH-1:0]        en_q,
  input logic [NCH-1:0][1:0]   st_q,
  input logic [NCH-1:0]        done_i,
  input logic [NCH-1:0][NCAUSE-1:0] sts_q,
  input logic [NCH-1:0][NCAUSE-1:0] msk_q,
  input logic [NCH-1:0]        irq_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R4
    rst_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q[g] |=> !rst_q[g]);
    // R4
    rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q[g] |=> st_q[g] == 2'd0);
    // R5
    off_not_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[g] |=> st_q[g] != 2'd1);
    // R5
    state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[g] != 2'd3);
    // R6
    done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i[g] && st_q[g] == 2'd1 && !rst_q[g]) |=> sts_q[g][0]);
    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_q[g] == '1) |-> !irq_o[g]);
  end
endmodule

bind dma_chan_regfile dma_chan_regfile_chk #(.NCH(NCH), .NCAUSE(NCAUSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_q(rst_q), .en_q(en_q), .st_q(st_q),
  .done_i(done_i), .sts_q(sts_q), .msk_q(msk_q), .irq_o(irq_o)
);

// File: tb/dma_chan_regfile_tb.sv
module dma_chan_regfile_tb;
  localparam int NCH = 4, AW = 16, PW = 10, NC = 13;
  localparam logic [31:0] PMASK = (32'd1 << PW) - 1;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] done_i = '0, irq_o;
  logic [NCH*NC-1:0] cause_i = '0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_chan_regfile #(.NCH(NCH), .AW(AW), .PTR_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done_i(done_i), .cause_i(cause_i), .irq_o(irq_o));

  function automatic logic [AW-1:0] ad(int ch, int off);
    return AW'(ch * 256 + off);
  endfunction
  function automatic logic [31:0] pat(int ch, int off);
    return 32'hA53C_96E1 ^ (ch * 32'h0101_1001) ^ (off * 32'h0004_0C03);
  endfunction
  function automatic logic [31:0] keep(int off, logic [31:0] v);
    case (off)
      'h00, 'h04, 'h10, 'h14: return v;
      'h08, 'h0C, 'h18, 'h1C: return v & PMASK;
      'h20: return v & 32'h11;
      'h44: return v & 32'h1FFF;
      default: return 0;
    endcase
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask
  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask
  task automatic chkr(string req, logic [AW-1:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); chk(req, d, exp);
  endtask
  task automatic pulse_done(int ch);
    @(negedge clk); done_i[ch] = 1;
    @(negedge clk); done_i[ch] = 0;
  endtask

  int offs[9] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h1C, 'h44};

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // reset values (R8 mask, R9 mode, R5 state)
    chkr("R8", ad(0, 'h44), 32'h1FFF);
    chkr("R9", AW'(16'h217C), 0);
    chkr("R5", ad(1, 'h30), 0);
    chkr("R3", ad(2, 'h20), 0);
    chk("R8", 32'(irq_o), 0);

    // R1/R2 sweep over all windows plus one out-of-range window
    for (int c = 0; c <= NCH; c++)
      foreach (offs[i]) wr(ad(c, offs[i]), pat(c, offs[i]));
    for (int c = 0; c <= NCH; c++)
      foreach (offs[i])
        chkr(c == NCH ? "R1" : "R2", ad(c, offs[i]),
             c == NCH ? 32'h0 : keep(offs[i], pat(c, offs[i])));

    // R10 undefined offsets
    for (int o = 0; o < 256; o += 4) begin
      if (!(o <= 'h24 || o == 'h30 || o == 'h40 || o == 'h44)) begin
        wr(ad(1, o), 32'hFFFF_FFFF);
        chkr("R10", ad(1, o), 0);
      end
    end
    foreach (offs[i]) chkr("R10", ad(1, offs[i]), keep(offs[i], pat(1, offs[i])));

    // R3 control bits
    wr(ad(3, 'h20), 32'hFFFF_FFFF);
    chkr("R3", ad(3, 'h20), 32'h11);
    wr(ad(3, 'h20), 0);

    // R9 mode
    wr(AW'(16'h217C), 32'hFFFF_FFFF);
    chkr("R9", AW'(16'h217C), 1);

    // clean start
    rst_n = 0; tick(); rst_n = 1; tick();

    // R5/R6 state machine on channel 2, ring of 4 entries
    wr(ad(2, 'h08), 3);
    wr(ad(2, 'h44), 0);
    wr(ad(2, 'h20), 1); tick();
    chkr("R5", ad(2, 'h30), 0);
    wr(ad(2, 'h0C), 2); tick();
    chkr("R5", ad(2, 'h30), 1);
    wr(ad(2, 'h20), 32'h11); tick();
    chkr("R5", ad(2, 'h30), 2);
    pulse_done(2); tick();
    chkr("R6", ad(2, 'h40), 0);
    wr(ad(2, 'h20), 1); tick();
    chkr("R5", ad(2, 'h30), 1);
    pulse_done(2); tick();
    chkr("R5", ad(2, 'h30), 1);
    pulse_done(2); tick();
    chkr("R6", ad(2, 'h30), 0);
    chkr("R6", ad(2, 'h40), 1);
    chk("R8", 32'(irq_o[2]), 1);
    wr(ad(2, 'h40), 1);
    chkr("R7", ad(2, 'h40), 0);
    chk("R8", 32'(irq_o[2]), 0);
    // wrap: consumer at 2, tail to 1 needs three pulses
    wr(ad(2, 'h0C), 1); tick();
    chkr("R6", ad(2, 'h30), 1);
    pulse_done(2); tick();
    pulse_done(2); tick();
    chkr("R6", ad(2, 'h30), 1);
    pulse_done(2); tick();
    chkr("R6", ad(2, 'h30), 0);
    wr(ad(2, 'h40), 32'h1FFF);
    pulse_done(2); tick();
    chkr("R6", ad(2, 'h40), 0);

    // R5 disable leaves RUN
    wr(ad(2, 'h0C), 3); tick();
    chkr("R5", ad(2, 'h30), 1);
    wr(ad(2, 'h20), 0); tick();
    chkr("R5", ad(2, 'h30), 0);

    // R4 reset request
    wr(ad(2, 'h20), 1); tick();
    wr(ad(2, 'h1C), 5);
    chkr("R5", ad(2, 'h30), 1);
    wr(ad(2, 'h24), 1);
    chkr("R4", ad(2, 'h24), 1);
    tick();
    chkr("R4", ad(2, 'h24), 0);
    chkr("R4", ad(2, 'h0C), 0);
    chkr("R4", ad(2, 'h1C), 0);
    chkr("R4", ad(2, 'h30), 0);
    chkr("R4", ad(2, 'h20), 1);
    wr(ad(2, 'h0C), 1); tick();
    chkr("R4", ad(2, 'h30), 1);

    // R7/R8 causes on channel 3
    @(negedge clk); cause_i[3*NC+12] = 1;
    @(negedge clk); cause_i[3*NC+12] = 0;
    chkr("R7", ad(3, 'h40), 32'h1000);
    chk("R8", 32'(irq_o[3]), 0);
    wr(ad(3, 'h44), 32'h0FFF);
    chk("R8", 32'(irq_o[3]), 1);
    chk("R8", 32'(irq_o[1:0]), 0);
    @(negedge clk); wr_en = 1; addr = ad(3, 'h40); wdata = 32'h1000;
    cause_i[3*NC+12] = 1;
    @(negedge clk); wr_en = 0; cause_i[3*NC+12] = 0;
    chkr("R7", ad(3, 'h40), 32'h1000);
    wr(ad(3, 'h40), 32'h1000);
    chkr("R7", ad(3, 'h40), 0);
    chk("R8", 32'(irq_o[3]), 0);
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule